// File: doc/BRIEF.md
# E1 Automatic Alarm Response Controller

This block sits beside an E1 framer and turns the receiver's status flags into the automatic consequent actions on both directions of the link. It takes loss of frame alignment, loss of signal, loss of CAS multiframe alignment, receive slip and the CRC outcome of each completed submultiframe. From these it drives the outgoing remote-alarm bit, the E-bits for the next outgoing CRC multiframe, an all-ones substitution toward the receive system side, a freeze on the 16-entry received signaling store, and the choice between the recovered line clock and the local master clock.

Each action has its own configuration bit. Every result is registered, so a change on an input shows at the outputs after one clock edge. The signaling store is part of the block: the framer writes through a write port, which the freeze control gates, and the system side reads it through a combinational read port.

Top module: `e1_alarm_ctrl`

## Requirements
- R1: While `rst_n` is low and after release with quiet inputs, `tx_remote_alarm`, `rx_ais_force`, `sig_freeze` and `clk_sel_master` are 0. `tx_ebits` is all ones. Every signaling entry reads 0.
- R2: With `cfg_auto_ra_en`=1, `tx_remote_alarm` equals `rx_lfa` one cycle later. With `cfg_auto_ra_en`=0, it is 0 one cycle later.
- R3: One cycle after a cycle with `rx_lfa`=1 and `cfg_ais_dis`=0, `rx_ais_force`=1 and `rx_sys_data` is all ones. In any other cycle, `rx_ais_force` is 0 one cycle later and `rx_sys_data` equals that cycle's `rx_data`.
- R4: Each `smf_done` pulse shifts `smf_crc_ok` into a history of the two latest submultiframes. In the cycle after a `tx_mf_start` pulse with `cfg_auto_ebit_en`=1, `tx_ebits` shows the history: bit 1 holds the older result and bit 0 the newer one, with 1 meaning CRC good. Without a `tx_mf_start` pulse, `tx_ebits` holds its value.
- R5: In the cycle after a `tx_mf_start` pulse with `cfg_auto_ebit_en`=0, `tx_ebits` is all ones.
- R6: With `cfg_slave_mode`=1 and `cfg_auto_clk_dis`=0, `clk_sel_master` equals `rx_los` one cycle later. 1 selects the master clock.
- R7: With `cfg_slave_mode`=1 and `cfg_auto_clk_dis`=1, `clk_sel_master` is 0 one cycle later. With `cfg_slave_mode`=0, it is 1 one cycle later.
- R8: With `cfg_freeze_dis`=0, a cycle with `rx_los`, `rx_cas_lma` or `rx_slip` high sets `sig_freeze` in the next cycle. A write in that same cycle is discarded, and so is every write while `sig_freeze` is 1.
- R9: `sig_freeze` falls in the cycle after the second `cas_mf_start` pulse that follows the last trigger cycle. A trigger in the same cycle as a pulse counts as a trigger, and that pulse does not count toward the two.
- R10: With `cfg_freeze_dis`=1, `sig_freeze` is 0 one cycle later, and triggers do not block writes.
- R11: A write that is not blocked is visible on `sig_rdata` at `sig_raddr` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_auto_ra_en | input | 1 | Enable automatic remote alarm |
| cfg_auto_ebit_en | input | 1 | Enable automatic E-bit insertion |
| cfg_ais_dis | input | 1 | Pass received data through instead of forcing AIS |
| cfg_slave_mode | input | 1 | 1: follow recovered clock, 0: master clock |
| cfg_auto_clk_dis | input | 1 | Disable automatic switch to master on LOS |
| cfg_freeze_dis | input | 1 | Disable automatic signaling freeze |
| rx_lfa | input | 1 | Loss of frame alignment |
| rx_los | input | 1 | Loss of signal |
| rx_cas_lma | input | 1 | Loss of CAS multiframe alignment |
| rx_slip | input | 1 | Receive slip pulse |
| smf_done | input | 1 | Received submultiframe completed |
| smf_crc_ok | input | 1 | CRC of the completed submultiframe is good |
| tx_mf_start | input | 1 | Outgoing CRC multiframe boundary |
| cas_mf_start | input | 1 | Received CAS multiframe boundary |
| rx_data | input | DATA_W | Received data toward the system side |
| sig_wr | input | 1 | Signaling store write strobe |
| sig_waddr | input | log2(SIG_DEPTH) | Signaling write address |
| sig_wdata | input | SIG_W | Signaling write data |
| sig_raddr | input | log2(SIG_DEPTH) | Signaling read address |
| tx_remote_alarm | output | 1 | Outgoing remote-alarm bit |
| tx_ebits | output | EBIT_W | E-bits for the outgoing multiframe |
| rx_sys_data | output | DATA_W | Data to the receive system side |
| rx_ais_force | output | 1 | AIS is being substituted |
| sig_freeze | output | 1 | Signaling store is frozen |
| sig_rdata | output | SIG_W | Signaling read data |
| clk_sel_master | output | 1 | 1: master clock, 0: recovered clock |

## Verification
Remote alarm, AIS substitution, clock selection and freeze assertion each show one edge after the input change. The bench drives inputs just after a falling edge and samples at the next falling edge, so exactly one rising edge lies between stimulus and check. The E-bit update and a freeze release show one edge after their boundary pulse. The bench samples there, and it also checks that nothing moves in the cycles between boundaries. Writes into the signaling store are checked one edge later on the read port.

// File: rtl/e1_alarm_pkg.sv
`timescale 1ns/1ps
// Shared types for the E1 alarm response controller.
package e1_alarm_pkg;
    // Clock source selection encoding driven to the clock generator.
    typedef enum logic {
        CLK_RECOVERED = 1'b0,
        CLK_MASTER    = 1'b1
    } clk_src_e;
endpackage

// File: rtl/e1_ebit_path.sv
`timescale 1ns/1ps
// E-bit path: keeps the CRC outcomes of the latest EBIT_W submultiframes
// and loads them into the outgoing E-bits at each outgoing multiframe start.
// Assumes smf_done and tx_mf_start are single-cycle strobes.
module e1_ebit_path #(
    parameter int EBIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              smf_done,
    input  logic              crc_ok,
    input  logic              tx_mf_start,
    output logic [EBIT_W-1:0] ebits
);
    logic [EBIT_W-1:0] hist_q;
    logic [EBIT_W-1:0] hist_next;

    // Next history: newest result enters at bit 0.
    generate
        if (EBIT_W == 1) begin : g_single
            assign hist_next = crc_ok;
        end else begin : g_shift
            assign hist_next = {hist_q[EBIT_W-2:0], crc_ok};
        end
    endgenerate

    // Record each completed submultiframe result.
    always_ff @(posedge clk) begin
        if (!rst_n)        hist_q <= '1;
        else if (smf_done) hist_q <= hist_next;
    end

    // Load outgoing E-bits at the multiframe boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)           ebits <= '1;
        else if (tx_mf_start) ebits <= en ? hist_q : '1;
    end

    assert_ebits_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_mf_start |=> $stable(ebits));
    assert_ebits_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mf_start && !en) |=> (ebits == '1));
endmodule

// File: rtl/e1_clk_select.sv
`timescale 1ns/1ps
// Clock source select: in slave mode follows the recovered clock and
// switches to the master clock during loss of signal unless disabled.
// Output is a register so the select never glitches.
module e1_clk_select
    import e1_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic slave_mode,
    input  logic auto_dis,
    input  logic los,
    output logic sel_master
);
    clk_src_e src_q;
    clk_src_e src_next;

    // Choose source for the next cycle.
    always_comb begin
        if (!slave_mode)          src_next = CLK_MASTER;
        else if (los && !auto_dis) src_next = CLK_MASTER;
        else                       src_next = CLK_RECOVERED;
    end

    // Register the selection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= CLK_RECOVERED;
        else        src_q <= src_next;
    end

    assign sel_master = (src_q == CLK_MASTER);

    assert_los_master_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && !auto_dis && los) |=> sel_master);
    assert_master_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !slave_mode |=> sel_master);
endmodule

// File: rtl/e1_sig_freeze.sv
`timescale 1ns/1ps
// Signaling freeze and received signaling store. Freeze is set by any
// trigger and released at the second CAS multiframe boundary after the
// last trigger, so a full trigger-free multiframe has passed.
// Assumes cas_mf_start is a single-cycle strobe.
module e1_sig_freeze #(
    parameter int SIG_DEPTH = 16,
    parameter int SIG_W     = 4,
    localparam int ADDR_W   = $clog2(SIG_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dis,
    input  logic              los,
    input  logic              cas_lma,
    input  logic              slip,
    input  logic              cas_mf_start,
    input  logic              wr,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [SIG_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [SIG_W-1:0]  rdata,
    output logic              freeze
);
    logic trig;
    logic armed_q;
    logic wr_en;
    logic [SIG_W-1:0] store_q [SIG_DEPTH];

    assign trig  = (los || cas_lma || slip) && !dis;
    assign wr_en = wr && !freeze && !trig;

    // Freeze state: set on trigger, arm at first clean boundary, release at next.
    always_ff @(posedge clk) begin
        if (!rst_n || dis) begin
            freeze  <= 1'b0;
            armed_q <= 1'b0;
        end else if (trig) begin
            freeze  <= 1'b1;
            armed_q <= 1'b0;
        end else if (freeze && cas_mf_start) begin
            if (armed_q) begin
                freeze  <= 1'b0;
                armed_q <= 1'b0;
            end else begin
                armed_q <= 1'b1;
            end
        end
    end

    // One register per signaling entry, written when not frozen.
    generate
        for (genvar i = 0; i < SIG_DEPTH; i++) begin : g_entry
            always_ff @(posedge clk) begin
                if (!rst_n)                               store_q[i] <= '0;
                else if (wr_en && (waddr == ADDR_W'(i)))  store_q[i] <= wdata;
            end
        end
    endgenerate

    assign rdata = store_q[raddr];

    assert_freeze_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dis && (los || cas_lma || slip)) |=> freeze);
    assert_release_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(freeze) && !$past(dis)) |-> $past(cas_mf_start));
    assert_freeze_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> !freeze);
endmodule

// File: rtl/e1_alarm_ctrl.sv
`timescale 1ns/1ps
// E1 automatic alarm response controller (top). Registers remote alarm and
// AIS substitution locally and instantiates the E-bit, clock select and
// signaling freeze paths. All outputs change one edge after their cause.
module e1_alarm_ctrl #(
    parameter int DATA_W    = 8,
    parameter int EBIT_W    = 2,
    parameter int SIG_DEPTH = 16,
    parameter int SIG_W     = 4,
    localparam int ADDR_W   = $clog2(SIG_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_auto_ra_en,
    input  logic              cfg_auto_ebit_en,
    input  logic              cfg_ais_dis,
    input  logic              cfg_slave_mode,
    input  logic              cfg_auto_clk_dis,
    input  logic              cfg_freeze_dis,
    input  logic              rx_lfa,
    input  logic              rx_los,
    input  logic              rx_cas_lma,
    input  logic              rx_slip,
    input  logic              smf_done,
    input  logic              smf_crc_ok,
    input  logic              tx_mf_start,
    input  logic              cas_mf_start,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              sig_wr,
    input  logic [ADDR_W-1:0] sig_waddr,
    input  logic [SIG_W-1:0]  sig_wdata,
    input  logic [ADDR_W-1:0] sig_raddr,
    output logic              tx_remote_alarm,
    output logic [EBIT_W-1:0] tx_ebits,
    output logic [DATA_W-1:0] rx_sys_data,
    output logic              rx_ais_force,
    output logic              sig_freeze,
    output logic [SIG_W-1:0]  sig_rdata,
    output logic              clk_sel_master
);
    logic ais_now;
    assign ais_now = rx_lfa && !cfg_ais_dis;

    // Remote alarm and AIS substitution registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_remote_alarm <= 1'b0;
            rx_ais_force    <= 1'b0;
            rx_sys_data     <= '0;
        end else begin
            tx_remote_alarm <= cfg_auto_ra_en && rx_lfa;
            rx_ais_force    <= ais_now;
            rx_sys_data     <= ais_now ? '1 : rx_data;
        end
    end

    e1_ebit_path #(.EBIT_W(EBIT_W)) u_ebit (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (cfg_auto_ebit_en),
        .smf_done    (smf_done),
        .crc_ok      (smf_crc_ok),
        .tx_mf_start (tx_mf_start),
        .ebits       (tx_ebits)
    );

    e1_clk_select u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .slave_mode (cfg_slave_mode),
        .auto_dis   (cfg_auto_clk_dis),
        .los        (rx_los),
        .sel_master (clk_sel_master)
    );

    e1_sig_freeze #(.SIG_DEPTH(SIG_DEPTH), .SIG_W(SIG_W)) u_frz (
        .clk          (clk),
        .rst_n        (rst_n),
        .dis          (cfg_freeze_dis),
        .los          (rx_los),
        .cas_lma      (rx_cas_lma),
        .slip         (rx_slip),
        .cas_mf_start (cas_mf_start),
        .wr           (sig_wr),
        .waddr        (sig_waddr),
        .wdata        (sig_wdata),
        .raddr        (sig_raddr),
        .rdata        (sig_rdata),
        .freeze       (sig_freeze)
    );

    assert_ra_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_remote_alarm) |-> $past(rx_lfa));
    assert_ais_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ais_force |-> (rx_sys_data == '1));
endmodule

// File: tb/e1_alarm_ctrl_tb_top.sv
`timescale 1ns/1ps
// Directed bench for e1_alarm_ctrl. Inputs change just after a falling
// edge; results are sampled at the following falling edge.
module e1_alarm_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n;
    logic cfg_auto_ra_en, cfg_auto_ebit_en, cfg_ais_dis, cfg_slave_mode;
    logic cfg_auto_clk_dis, cfg_freeze_dis;
    logic rx_lfa, rx_los, rx_cas_lma, rx_slip;
    logic smf_done, smf_crc_ok, tx_mf_start, cas_mf_start;
    logic [7:0] rx_data;
    logic sig_wr;
    logic [3:0] sig_waddr, sig_raddr;
    logic [3:0] sig_wdata;
    logic tx_remote_alarm, rx_ais_force, sig_freeze, clk_sel_master;
    logic [1:0] tx_ebits;
    logic [7:0] rx_sys_data;
    logic [3:0] sig_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    e1_alarm_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_auto_ra_en(cfg_auto_ra_en), .cfg_auto_ebit_en(cfg_auto_ebit_en),
        .cfg_ais_dis(cfg_ais_dis), .cfg_slave_mode(cfg_slave_mode),
        .cfg_auto_clk_dis(cfg_auto_clk_dis), .cfg_freeze_dis(cfg_freeze_dis),
        .rx_lfa(rx_lfa), .rx_los(rx_los), .rx_cas_lma(rx_cas_lma), .rx_slip(rx_slip),
        .smf_done(smf_done), .smf_crc_ok(smf_crc_ok), .tx_mf_start(tx_mf_start),
        .cas_mf_start(cas_mf_start), .rx_data(rx_data),
        .sig_wr(sig_wr), .sig_waddr(sig_waddr), .sig_wdata(sig_wdata),
        .sig_raddr(sig_raddr),
        .tx_remote_alarm(tx_remote_alarm), .tx_ebits(tx_ebits),
        .rx_sys_data(rx_sys_data), .rx_ais_force(rx_ais_force),
        .sig_freeze(sig_freeze), .sig_rdata(sig_rdata),
        .clk_sel_master(clk_sel_master)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic smf(input logic ok);
        smf_done = 1'b1; smf_crc_ok = ok; tick();
        smf_done = 1'b0;
    endtask

    task automatic tx_boundary();
        tx_mf_start = 1'b1; tick();
        tx_mf_start = 1'b0;
    endtask

    task automatic cas_boundary();
        cas_mf_start = 1'b1; tick();
        cas_mf_start = 1'b0;
    endtask

    task automatic write_sig(input logic [3:0] a, input logic [3:0] d);
        sig_wr = 1'b1; sig_waddr = a; sig_wdata = d; tick();
        sig_wr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cfg_auto_ra_en = 1'b0; cfg_auto_ebit_en = 1'b0; cfg_ais_dis = 1'b0;
        cfg_slave_mode = 1'b1; cfg_auto_clk_dis = 1'b0; cfg_freeze_dis = 1'b0;
        rx_lfa = 0; rx_los = 0; rx_cas_lma = 0; rx_slip = 0;
        smf_done = 0; smf_crc_ok = 0; tx_mf_start = 0; cas_mf_start = 0;
        rx_data = 8'h00; sig_wr = 0; sig_waddr = 0; sig_wdata = 0; sig_raddr = 0;
        tick(3);
        rst_n = 1'b1;
        tick();
        check(tx_remote_alarm == 0 && rx_ais_force == 0 && sig_freeze == 0 && clk_sel_master == 0,
              "R1 flags", {tx_remote_alarm, rx_ais_force, sig_freeze, clk_sel_master}, 0);
        check(tx_ebits == 2'b11, "R1 ebits", tx_ebits, 3);
        sig_raddr = 4'd7;
        #1 check(sig_rdata == 0, "R1 store", sig_rdata, 0);
    endtask

    task automatic t_remote_alarm();
        cfg_auto_ra_en = 1; rx_lfa = 1; tick();
        check(tx_remote_alarm == 1, "R2 set", tx_remote_alarm, 1);
        rx_lfa = 0; tick();
        check(tx_remote_alarm == 0, "R2 clear", tx_remote_alarm, 0);
        cfg_auto_ra_en = 0; rx_lfa = 1; tick();
        check(tx_remote_alarm == 0, "R2 disabled", tx_remote_alarm, 0);
        rx_lfa = 0; tick();
    endtask

    task automatic t_ais();
        rx_data = 8'h5A; tick();
        check(rx_sys_data == 8'h5A && !rx_ais_force, "R3 pass", rx_sys_data, 8'h5A);
        rx_lfa = 1; rx_data = 8'h3C; tick();
        check(rx_sys_data == 8'hFF && rx_ais_force, "R3 forced", rx_sys_data, 8'hFF);
        cfg_ais_dis = 1; tick();
        check(rx_sys_data == 8'h3C && !rx_ais_force, "R3 disabled", rx_sys_data, 8'h3C);
        cfg_ais_dis = 0; rx_lfa = 0; tick();
    endtask

    task automatic t_ebits();
        cfg_auto_ebit_en = 1;
        smf(1'b0); smf(1'b1);
        tx_boundary();
        check(tx_ebits == 2'b01, "R4 load", tx_ebits, 1);
        smf(1'b1); smf(1'b1); tick(2);
        check(tx_ebits == 2'b01, "R4 hold", tx_ebits, 1);
        tx_boundary();
        check(tx_ebits == 2'b11, "R4 reload", tx_ebits, 3);
        smf(1'b1); smf(1'b0);
        tx_boundary();
        check(tx_ebits == 2'b10, "R4 order", tx_ebits, 2);
        smf(1'b0);
        cfg_auto_ebit_en = 0;
        tx_boundary();
        check(tx_ebits == 2'b11, "R5 disabled", tx_ebits, 3);
        cfg_auto_ebit_en = 1;
        tx_boundary();
        check(tx_ebits == 2'b00, "R4 after enable", tx_ebits, 0);
    endtask

    task automatic t_clock();
        cfg_freeze_dis = 1;
        rx_los = 1; tick();
        check(clk_sel_master == 1, "R6 to master", clk_sel_master, 1);
        rx_los = 0; tick();
        check(clk_sel_master == 0, "R6 back", clk_sel_master, 0);
        cfg_auto_clk_dis = 1; rx_los = 1; tick();
        check(clk_sel_master == 0, "R7 auto off", clk_sel_master, 0);
        rx_los = 0; cfg_auto_clk_dis = 0; cfg_slave_mode = 0; tick();
        check(clk_sel_master == 1, "R7 master mode", clk_sel_master, 1);
        cfg_slave_mode = 1; tick();
        cfg_freeze_dis = 0; tick();
    endtask

    task automatic t_freeze();
        sig_raddr = 4'd3;
        write_sig(4'd3, 4'h9);
        check(sig_rdata == 4'h9, "R11 write", sig_rdata, 9);
        rx_slip = 1; sig_wr = 1; sig_waddr = 4'd3; sig_wdata = 4'h5; tick();
        rx_slip = 0; sig_wr = 0;
        check(sig_freeze == 1, "R8 slip", sig_freeze, 1);
        check(sig_rdata == 4'h9, "R8 same-cycle write", sig_rdata, 9);
        write_sig(4'd3, 4'h6);
        check(sig_rdata == 4'h9, "R8 frozen write", sig_rdata, 9);
        tick(2); cas_boundary(); tick(3);
        check(sig_freeze == 1, "R9 first boundary", sig_freeze, 1);
        cas_boundary();
        check(sig_freeze == 0, "R9 release", sig_freeze, 0);
        write_sig(4'd3, 4'h7);
        check(sig_rdata == 4'h7, "R11 after release", sig_rdata, 7);
        rx_cas_lma = 1; tick(); rx_cas_lma = 0;
        check(sig_freeze == 1, "R8 cas loss", sig_freeze, 1);
        cas_boundary(); tick();
        rx_los = 1; tick(); rx_los = 0;
        cas_boundary();
        check(sig_freeze == 1, "R9 retrigger", sig_freeze, 1);
        rx_slip = 1; cas_mf_start = 1; tick(); rx_slip = 0; cas_mf_start = 0;
        cas_boundary();
        check(sig_freeze == 1, "R9 trigger on boundary", sig_freeze, 1);
        cas_boundary();
        check(sig_freeze == 0, "R9 release after retrigger", sig_freeze, 0);
    endtask

    task automatic t_freeze_dis();
        cfg_freeze_dis = 1; sig_raddr = 4'd12;
        rx_slip = 1; sig_wr = 1; sig_waddr = 4'd12; sig_wdata = 4'h2; tick();
        rx_slip = 0; sig_wr = 0;
        check(sig_freeze == 0, "R10 no freeze", sig_freeze, 0);
        check(sig_rdata == 4'h2, "R10 write taken", sig_rdata, 2);
        cfg_freeze_dis = 0;
    endtask

    initial begin
        t_reset();
        t_remote_alarm();
        t_ais();
        t_ebits();
        t_clock();
        t_freeze();
        t_freeze_dis();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule